// File: doc/BRIEF.md
# Serial Flash Configuration Register Write Sequencer

This block sits on the host side of a serial flash link. Its job is to update one of the flash's configuration registers. A request names the target register (two-byte nonvolatile or one-byte volatile), the data value and the lane mode. The block then runs three kinds of chip-select-framed transactions on its own. First comes a write-enable command. Next comes the register-write command with its data bytes. After that comes a series of flag-status polls that watch the device's self-timed operation until it finishes.

Command and data leave most-significant bit first. They go out on one, two or four lanes, and each bit-group takes one serial clock beat. The sequencer ends when it has read the ready bit as 1 in a set number of consecutive poll frames. It also ends if a cycle budget counted from the end of the write runs out, in which case it flags a timeout. The data lanes appear as separate output, output-enable and input vectors, so the chip's pad ring can build the bidirectional pins.

Top module: `flash_cfg_writer`

## Requirements
- R1: After reset, csN is 1, sclk is 0, dqOe is 0, and busy, done and timedOut are 0.
- R2: An accepted request produces frames in a fixed order, each in its own csN-low period: a write-enable frame carrying only code 0x06, then one register-write frame, then poll frames carrying code 0x70.
- R3: reqLanes selects the lane mode: 0 sends on dqOut[0] only with dqOe=4'b0001, 1 sends on dqOut[1:0] with dqOe=4'b0011, and 2 (or 3) sends on dqOut[3:0] with dqOe=4'b1111. The highest used lane carries the earlier bit, and bytes go out MSB first. Each beat lasts two clocks, sclk low then sclk high, and the device samples on the rising edge.
- R4: With reqNonvol=1 the write frame is code 0xB1 followed by reqData[7:0] and then reqData[15:8] (24 bits). With reqNonvol=0 it is code 0x81 followed by reqData[7:0] (16 bits). csN rises on the clock right after the last beat of the write frame.
- R5: A poll frame sends 0x70 and then reads 8 bits MSB first with dqOe at 0. The read uses dqIn[1] in mode 0, dqIn[1:0] in mode 1 and dqIn[3:0] in mode 2. The first bit received (status bit 7) is the ready flag. No other status bit matters.
- R6: done is declared only after POLL_COUNT consecutive poll frames (default 4) have each read the ready flag as 1. A poll that reads 0 clears the run of ready readings, and polling continues.
- R7: A timeout counter starts from zero on the clock after the write frame's csN rises and counts every clock. Each poll result is judged in the first csN-high clock after that poll. If the counter has reached TIMEOUT_CYCLES at that point and the run of ready readings is not complete, polling stops with done and timedOut both 1.
- R8: If the final ready reading that completes the run is judged in the same clock that the timeout has been reached, the sequence ends as a success: done is 1 and timedOut is 0.
- R9: csN stays high for exactly CS_GAP clocks between frames, and for CS_GAP+1 clocks after a poll frame. While csN is high, sclk is 0 and dqOe is 0.
- R10: busy is 1 from the clock after an accepted request until the clock in which done pulses for a single clock. A reqValid seen while busy is ignored and changes neither the frames sent nor the activity after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, accepted only while idle |
| reqNonvol | input | 1 | 1 = two-byte nonvolatile register, 0 = one-byte volatile register |
| reqData | input | 16 | Register value; low byte sent first |
| reqLanes | input | 2 | Lane mode: 0 single, 1 dual, 2 or 3 quad |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| timedOut | output | 1 | Pulses with done when polling ran out of time |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| dqOut | output | 4 | Data lane output values |
| dqOe | output | 4 | Data lane output enables |
| dqIn | input | 4 | Data lane input values |

## Verification
Two functions can meet in one clock: the completion of the ready-reading run and the expiry of the timeout. Both are judged in the evaluation clock after a poll. The bench works out from the beat and gap timing which poll is the first one judged after the timeout is reached. It then gives the device model ready flags so that the fourth consecutive ready reading lands on exactly that poll, and expects success with no timeout. It also runs the variant with one ready reading fewer, and expects a timeout on that same poll.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  typedef enum logic [1:0] {
    FR_WREN  = 2'd0,
    FR_WRITE = 2'd1,
    FR_POLL  = 2'd2
  } frameKind_t;

  // strobes from sequencing control to the serializer datapath
  typedef struct packed {
    logic       accept;
    logic       load;
    frameKind_t kind;
    logic       run;
  } dpStrobe_t;

endpackage

// File: rtl/flash_cfg_datapath.sv
module flash_cfg_datapath
  import flash_cfg_pkg::*;
#(
  parameter logic [7:0] CMD_WREN  = 8'h06,
  parameter logic [7:0] CMD_WR_NV = 8'hB1,
  parameter logic [7:0] CMD_WR_V  = 8'h81,
  parameter logic [7:0] CMD_POLL  = 8'h70,
  parameter int         DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              reqNonvol,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqLanes,
  input  logic [3:0]        dqIn,
  output logic              sclk,
  output logic [3:0]        dqOut,
  output logic [3:0]        dqOe,
  output logic              frameEnd,
  output logic              statusReady
);

  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  dataQ;
  logic               nonvolQ;
  logic [1:0]         laneQ;
  logic [FRAME_W-1:0] txSh;
  logic [FRAME_W-1:0] frameImg;
  logic [FRAME_W-1:0] txShNext;
  logic [BYTE_W-1:0]  rxSh;
  logic [BYTE_W-1:0]  rxNext;
  logic [CNT_W-1:0]   beatsLeft;
  logic [CNT_W-1:0]   txLeft;
  logic [CNT_W-1:0]   frameBits;
  logic [3:0]         laneMask;
  logic [3:0]         laneVal;
  logic               halfQ;

  // frame image, left aligned, low data byte first
  always_comb begin
    frameImg  = '0;
    frameBits = CNT_W'(2 * BYTE_W);
    unique case (strb.kind)
      FR_WREN: begin
        frameImg  = {CMD_WREN, {DATA_W{1'b0}}};
        frameBits = CNT_W'(BYTE_W);
      end
      FR_WRITE: begin
        if (nonvolQ) begin
          frameImg  = {CMD_WR_NV, dataQ[7:0], dataQ[DATA_W-1:8]};
          frameBits = CNT_W'(FRAME_W);
        end else begin
          frameImg  = {CMD_WR_V, dataQ[7:0], {(DATA_W-8){1'b0}}};
          frameBits = CNT_W'(2 * BYTE_W);
        end
      end
      default: begin
        frameImg  = {CMD_POLL, {DATA_W{1'b0}}};
        frameBits = CNT_W'(2 * BYTE_W);
      end
    endcase
  end

  always_comb begin
    unique case (laneQ)
      2'd0: begin
        laneMask = 4'b0001;
        laneVal  = {3'b000, txSh[FRAME_W-1]};
        txShNext = txSh << 1;
        rxNext   = {rxSh[BYTE_W-2:0], dqIn[1]};
      end
      2'd1: begin
        laneMask = 4'b0011;
        laneVal  = {2'b00, txSh[FRAME_W-1 -: 2]};
        txShNext = txSh << 2;
        rxNext   = {rxSh[BYTE_W-3:0], dqIn[1:0]};
      end
      default: begin
        laneMask = 4'b1111;
        laneVal  = txSh[FRAME_W-1 -: 4];
        txShNext = txSh << 4;
        rxNext   = {rxSh[BYTE_W-5:0], dqIn};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ     <= '0;
      nonvolQ   <= 1'b0;
      laneQ     <= 2'd0;
      txSh      <= '0;
      rxSh      <= '0;
      beatsLeft <= '0;
      txLeft    <= '0;
      halfQ     <= 1'b0;
    end else begin
      if (strb.accept) begin
        dataQ   <= reqData;
        nonvolQ <= reqNonvol;
        laneQ   <= (reqLanes == 2'd3) ? 2'd2 : reqLanes;
      end
      if (strb.load) begin
        txSh      <= frameImg;
        rxSh      <= '0;
        beatsLeft <= frameBits >> laneQ;
        txLeft    <= CNT_W'(BYTE_W) >> laneQ;
        if (strb.kind != FR_POLL) txLeft <= frameBits >> laneQ;
        halfQ     <= 1'b0;
      end else if (strb.run) begin
        halfQ <= ~halfQ;
        if (halfQ) begin
          beatsLeft <= beatsLeft - 1'b1;
          if (txLeft != '0) begin
            txSh   <= txShNext;
            txLeft <= txLeft - 1'b1;
          end else begin
            rxSh <= rxNext;
          end
        end
      end
    end
  end

  assign sclk        = strb.run & halfQ;
  assign frameEnd    = strb.run & halfQ & (beatsLeft == CNT_W'(1));
  assign dqOut       = strb.run ? laneVal : 4'b0000;
  assign dqOe        = (strb.run && txLeft != '0) ? laneMask : 4'b0000;
  assign statusReady = rxSh[BYTE_W-1];

  a_r3_sclk_alternates: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !frameEnd && !strb.load) |=> (sclk != $past(sclk)));

  a_r4_all_sent_at_end: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (txLeft == '0 || (txLeft == CNT_W'(1) && beatsLeft == CNT_W'(1))));

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(dataQ));

endmodule

// File: rtl/flash_cfg_ctrl.sv
module flash_cfg_ctrl
  import flash_cfg_pkg::*;
#(
  parameter int CS_GAP         = 3,
  parameter int POLL_COUNT     = 4,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      frameEnd,
  input  logic      statusReady,
  output dpStrobe_t strb,
  output logic      csN,
  output logic      busy,
  output logic      done,
  output logic      timedOut
);

  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int RDY_W = $clog2(POLL_COUNT + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [RDY_W-1:0] RDY_LAST = RDY_W'(POLL_COUNT - 1);
  localparam logic [TMO_W-1:0] TMO_MAX  = TMO_W'(TIMEOUT_CYCLES);

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SHIFT, ST_EVAL} state_t;

  state_t     state;
  frameKind_t nextKind;
  logic [GAP_W-1:0] gapCnt;
  logic [RDY_W-1:0] readyCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic doneQ, tmoQ;
  logic tmoHit, runComplete;

  assign tmoHit      = (tmoCnt == TMO_MAX);
  assign runComplete = statusReady && (readyCnt == RDY_LAST);

  always_comb begin
    strb.accept = (state == ST_IDLE) && reqValid;
    strb.load   = (state == ST_GAP) && (gapCnt == '0);
    strb.kind   = nextKind;
    strb.run    = (state == ST_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nextKind <= FR_WREN;
      gapCnt   <= '0;
      readyCnt <= '0;
      tmoCnt   <= '0;
      doneQ    <= 1'b0;
      tmoQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      tmoQ  <= 1'b0;
      if (state != ST_IDLE && nextKind == FR_POLL && !tmoHit)
        tmoCnt <= tmoCnt + 1'b1;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state    <= ST_GAP;
          gapCnt   <= GAP_LAST;
          nextKind <= FR_WREN;
        end
        ST_GAP: begin
          if (gapCnt == '0) state <= ST_SHIFT;
          else gapCnt <= gapCnt - 1'b1;
        end
        ST_SHIFT: if (frameEnd) begin
          gapCnt <= GAP_LAST;
          unique case (nextKind)
            FR_WREN: begin
              state    <= ST_GAP;
              nextKind <= FR_WRITE;
            end
            FR_WRITE: begin
              state    <= ST_GAP;
              nextKind <= FR_POLL;
              readyCnt <= '0;
              tmoCnt   <= '0;
            end
            default: state <= ST_EVAL;
          endcase
        end
        default: begin
          if (runComplete) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else if (tmoHit) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
            tmoQ  <= 1'b1;
          end else begin
            state    <= ST_GAP;
            readyCnt <= statusReady ? readyCnt + 1'b1 : '0;
          end
        end
      endcase
    end
  end

  assign csN      = (state != ST_SHIFT);
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;
  assign timedOut = tmoQ;

  a_r6_streak_bound: assert property (@(posedge clk) disable iff (!rstN)
    readyCnt < RDY_W'(POLL_COUNT));

  a_r8_ready_wins: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && runComplete && tmoHit) |=> (done && !timedOut));

  a_r2_wren_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && nextKind == FR_WREN) |=> (nextKind == FR_WRITE && csN));

endmodule

// File: rtl/flash_cfg_writer.sv
module flash_cfg_writer
  import flash_cfg_pkg::*;
#(
  parameter int CS_GAP         = 3,
  parameter int POLL_COUNT     = 4,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqNonvol,
  input  logic [15:0] reqData,
  input  logic [1:0]  reqLanes,
  output logic        busy,
  output logic        done,
  output logic        timedOut,
  output logic        csN,
  output logic        sclk,
  output logic [3:0]  dqOut,
  output logic [3:0]  dqOe,
  input  logic [3:0]  dqIn
);

  dpStrobe_t strb;
  logic frameEnd, statusReady;

  flash_cfg_ctrl #(
    .CS_GAP(CS_GAP), .POLL_COUNT(POLL_COUNT), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .frameEnd(frameEnd),
    .statusReady(statusReady), .strb(strb), .csN(csN), .busy(busy),
    .done(done), .timedOut(timedOut)
  );

  flash_cfg_datapath #(.DATA_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqNonvol(reqNonvol),
    .reqData(reqData), .reqLanes(reqLanes), .dqIn(dqIn), .sclk(sclk),
    .dqOut(dqOut), .dqOe(dqOe), .frameEnd(frameEnd), .statusReady(statusReady)
  );

  a_r9_quiet_when_high: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (dqOe == 4'b0000 && !sclk));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_timeout_marks_done: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> done);

  a_r10_busy_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

// File: tb/flash_cfg_writer_bench.sv
module flash_cfg_writer_bench;

  localparam int GAP = 3;
  localparam int NPOLL = 4;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqNonvol = 1'b0;
  logic [15:0] reqData = '0;
  logic [1:0] reqLanes = '0;
  logic busy, done, timedOut, csN, sclk;
  logic [3:0] dqOut, dqOe;
  logic [3:0] dqIn = '0;

  always #2 clk = ~clk;

  flash_cfg_writer #(.CS_GAP(GAP), .POLL_COUNT(NPOLL), .TIMEOUT_CYCLES(TMO)) u_flash_cfg_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNonvol(reqNonvol),
    .reqData(reqData), .reqLanes(reqLanes), .busy(busy), .done(done),
    .timedOut(timedOut), .csN(csN), .sclk(sclk), .dqOut(dqOut), .dqOe(dqOe),
    .dqIn(dqIn)
  );

  int checks = 0, fails = 0, cycles = 0;

  // device model state
  logic [31:0] fTx [64];
  int fBits [64], fBeats [64], fGap [64];
  bit readyAt [64];
  int frameCnt = 0, beats = 0, bitCnt = 0, csHigh = 0, gapStart = 0, oeErr = 0, curL = 1;
  logic [31:0] acc = '0;
  bit inFrame = 0, prevSclk = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] laneMaskFor(input int l);
    return (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : 4'b1111;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (csN) begin
      if (inFrame && frameCnt < 64) begin
        fTx[frameCnt] = acc; fBits[frameCnt] = bitCnt;
        fBeats[frameCnt] = beats; fGap[frameCnt] = gapStart;
        frameCnt++;
      end
      inFrame = 0;
      csHigh++;
      if (rstN && (dqOe != 4'b0000 || sclk)) oeErr++;
    end else begin
      if (!inFrame) begin
        inFrame = 1; gapStart = csHigh; csHigh = 0;
        beats = 0; bitCnt = 0; acc = '0;
      end
      if (!sclk) begin
        dqIn = 4'b0000;
        if (frameCnt >= 2 && frameCnt < 64 && beats >= 8 / curL) begin
          int r; int sh; logic [7:0] st; logic [7:0] v;
          r = beats - 8 / curL;
          st = readyAt[frameCnt - 2] ? 8'h81 : 8'h7E;
          sh = 8 - (r + 1) * curL;
          v = (st >> sh) & {4'b0000, laneMaskFor(curL)};
          dqIn = (curL == 1) ? {2'b00, v[0], 1'b0} : v[3:0];
        end
      end
      if (sclk && !prevSclk) begin
        if (dqOe != 4'b0000) begin
          if (dqOe != laneMaskFor(curL)) oeErr++;
          if (frameCnt >= 2 && bitCnt >= 8) oeErr++;
          acc = (acc << curL) | {28'd0, dqOut & laneMaskFor(curL)};
          bitCnt += curL;
        end else if (bitCnt < 8) oeErr++;
        beats++;
      end
    end
    prevSclk = sclk;
  end

  task automatic setStatus(input int zerosBefore, input int glitchAt);
    for (int i = 0; i < 64; i++) readyAt[i] = (i >= zerosBefore) && (i != glitchAt);
  endtask

  function automatic int pollsToTimeout(input int l);
    int per; int t; int n;
    per = GAP + 2 * (16 / l);
    t = per; n = 1;
    while (t < TMO) begin t += per + 1; n++; end
    return n;
  endfunction

  // runs one request; optional extra ignored request during busy
  task automatic runReq(input bit nv, input logic [15:0] d, input int laneCode,
                        input int expPolls, input bit expTmo, input bit poke, input string tag);
    int waitCnt; bit sawTmo; logic [31:0] expW; int l;
    l = (laneCode == 0) ? 1 : (laneCode == 1) ? 2 : 4;
    curL = l; frameCnt = 0; oeErr = 0;
    @(negedge clk);
    reqValid = 1; reqNonvol = nv; reqData = d; reqLanes = 2'(laneCode);
    @(negedge clk);
    reqValid = 0;
    check(busy === 1'b1, {tag, " R10 busy after accept"}, busy, 1);
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
      if (poke && waitCnt == 30) begin
        reqValid = 1; reqNonvol = ~nv; reqData = ~d; reqLanes = 2'd0;
      end else if (poke && waitCnt == 31) reqValid = 0;
    end
    check(done === 1'b1, {tag, " R10 done seen"}, done, 1);
    sawTmo = timedOut;
    check(busy === 1'b0, {tag, " R10 busy clear with done"}, busy, 0);
    check(sawTmo == expTmo, {tag, " R7 R8 timeout flag"}, sawTmo, expTmo);
    @(negedge clk);
    check(done === 1'b0, {tag, " R10 done one cycle"}, done, 0);
    check(frameCnt == 2 + expPolls, {tag, " R6 frame count"}, frameCnt, 2 + expPolls);
    check(fBits[0] == 8 && fTx[0][7:0] == 8'h06, {tag, " R2 write enable frame"}, fTx[0][7:0], 8'h06);
    check(fBeats[0] == 8 / l, {tag, " R3 beats per byte"}, fBeats[0], 8 / l);
    expW = nv ? {8'h00, 8'hB1, d[7:0], d[15:8]} : {16'h0000, 8'h81, d[7:0]};
    check(fBits[1] == (nv ? 24 : 16) && fTx[1] == expW, {tag, " R4 write frame"}, fTx[1], expW);
    check(fBeats[1] == (nv ? 24 : 16) / l, {tag, " R4 csN rise after last beat"}, fBeats[1], (nv ? 24 : 16) / l);
    check(fGap[1] == GAP, {tag, " R9 gap after enable"}, fGap[1], GAP);
    for (int i = 2; i < frameCnt && i < 64; i++) begin
      if (fBits[i] != 8 || fTx[i][7:0] != 8'h70 || fBeats[i] != 16 / l)
        check(0, {tag, " R5 poll frame"}, fTx[i][7:0], 8'h70);
      if (fGap[i] != ((i == 2) ? GAP : GAP + 1))
        check(0, {tag, " R9 gap before poll"}, fGap[i], (i == 2) ? GAP : GAP + 1);
    end
    check(oeErr == 0, {tag, " R3 R5 R9 lane enables"}, oeErr, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      check(frameCnt == 2 + expPolls && csN === 1'b1 && !busy, {tag, " R10 ignored request"}, frameCnt, 2 + expPolls);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b0 && dqOe === 4'b0000, "R1 link idle", {csN, sclk, dqOe}, 6'b100000);
    check(busy === 1'b0 && done === 1'b0 && timedOut === 1'b0, "R1 status idle", {busy, done, timedOut}, 0);
  endtask

  task automatic testVolatileSingle();
    setStatus(1, -1);
    runReq(1'b0, 16'h00C5, 0, 5, 1'b0, 1'b0, "vol x1");
  endtask

  task automatic testNonvolDualGlitch();
    setStatus(0, 2);
    runReq(1'b1, 16'h3C96, 1, 7, 1'b0, 1'b0, "nv x2 R6 streak reset");
  endtask

  task automatic testNonvolQuadIgnore();
    setStatus(0, -1);
    runReq(1'b1, 16'hE12D, 2, NPOLL, 1'b0, 1'b1, "nv x4");
  endtask

  task automatic testTimeoutSingle();
    setStatus(64, -1);
    runReq(1'b0, 16'h005A, 0, pollsToTimeout(1), 1'b1, 1'b0, "R7 timeout x1");
  endtask

  task automatic testCollision();
    int k;
    k = pollsToTimeout(4);
    setStatus(k - NPOLL, -1);
    runReq(1'b0, 16'h0033, 3, k, 1'b0, 1'b0, "R8 ready wins");
    setStatus(k - NPOLL + 1, -1);
    runReq(1'b0, 16'h0071, 2, k, 1'b1, 1'b0, "R8 one short");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testVolatileSingle();
    testNonvolDualGlitch();
    testNonvolQuadIgnore();
    testTimeoutSingle();
    testCollision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule